// File: doc/BRIEF.md
# Reset Qualification and Init Sequencer

This block sits between an external, active-low reset request and a small 4-bit controller core. It synchronizes the raw request to the core clock. It then counts instruction-cycle strobes while the synchronized request stays low. A core reset is raised only once the request has been seen low across three such strobes. Shorter dips are treated as noise and dropped. While the qualified low persists, the core is held in reset.

When reset is released, the block issues a one-clock set of initialization strobes in the first clock after release. These strobes clear the program counter to address zero, clear each working register through its own bit of a clear vector, and set the latch that makes the serial-clock pin drive a clock. Data memory is never cleared. Instead, a hold output tells the memory to ignore writes for the whole reset span and for the release clock, so its contents survive.

An internal power-on request is modelled as an input flag, gated by an option input. With the option set, the flag forces the core into reset and then produces the normal release strobes. With the option clear, only the external path can reset the core. In both cases the flag returns the sequencer's own state to idle.

Top module: `cyc_reset_qualifier`

## Requirements
- R1: `ext_rst_n` passes through a two-flop synchronizer. A level applied before a clock edge reaches the low-cycle counter two clocks later.
- R2: The low-cycle counter returns to zero on any clock at which the synchronized request reads high. A low that spans fewer than three `cyc_en` strobes never raises `core_rst`.
- R3: `core_rst` rises one clock after the clock that takes the third `cyc_en` strobe while the synchronized request is low. It then stays high for as long as the synchronized request stays low.
- R4: `core_rst` falls one clock after the synchronized request reads high. In the first clock with `core_rst` low, `pc_clr`, `sk_set` and every bit of `reg_clr` are 1, for exactly one clock. At all other times they are 0.
- R5: `reg_clr` carries one bit per working register (bit i clears register i). All bits pulse together.
- R6: `ram_hold` is 1 whenever `core_rst` is 1 and during the release clock, and 0 otherwise. No output ever clears data memory, so a memory that honours `ram_hold` keeps its contents across reset.
- R7: With `por_opt_en` = 1, `por_flag` = 1 makes `core_rst` 1 from the next clock for as long as the flag stays high. The release strobes of R4 follow in the first clock after the flag falls.
- R8: With `por_opt_en` = 0, `por_flag` = 1 raises neither `core_rst` nor any strobe. It only returns the sequencer to idle, and the external path still resets the core afterwards.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Core clock |
| cyc_en | input | 1 | Instruction-cycle strobe, one clock wide |
| ext_rst_n | input | 1 | Raw external reset request, active low, asynchronous |
| por_flag | input | 1 | Internal power-on request; also idles the sequencer |
| por_opt_en | input | 1 | Option: power-on request may reset the core |
| core_rst | output | 1 | Synchronous core reset, active high |
| pc_clr | output | 1 | Program counter clear strobe |
| reg_clr | output | NUM_WREGS | Per-register clear strobes |
| sk_set | output | 1 | Set strobe for the serial-clock output latch |
| ram_hold | output | 1 | Data memory write inhibit during reset and release |

## Verification
The release strobe can fall in the same clock in which the external request drops low again. In that clock the initialization strobes must still fire, and the low-cycle count must restart from zero. The bench provokes this by re-asserting the request just as the synchronized high arrives. It also uses a one-clock high glitch inside a long low and a power-on flag that overlaps an external low. A behavioural model, built from a queue for the synchronizer and an integer count, predicts every output on every clock, and the bench compares all outputs against it.

// File: rtl/rq_pkg.sv
package rq_pkg;
    localparam int unsigned RQ_LOW_CYCLES   = 3;
    localparam int unsigned RQ_SYNC_STAGES  = 2;
    localparam int unsigned RQ_NUM_WREGS    = 8;
endpackage

// File: rtl/rq_sync.sv
module rq_sync #(
    parameter int unsigned STAGES = 2
) (
    input  logic clk,
    input  logic por_i,
    input  logic d_i,
    output logic q_o
);
    typedef struct packed {
        logic [STAGES-1:0] sh;
    } sync_st_t;

    sync_st_t st_d, st_q;

    always_comb begin
        st_d = st_q;
        if (por_i) begin
            st_d.sh = '1;
        end else begin
            st_d.sh = {st_q.sh[STAGES-2:0], d_i};
        end
    end

    always_ff @(posedge clk) begin
        st_q <= st_d;
    end

    assign q_o = st_q.sh[STAGES-1];

    // R1: a level reaches the output exactly STAGES clocks later (checked for the last hop)
    a_r1_sync_delay: assert property (@(posedge clk) disable iff (por_i)
        !$past(por_i) |-> (q_o == $past(st_q.sh[STAGES-2])));
endmodule

// File: rtl/rq_lowcnt.sv
module rq_lowcnt #(
    parameter int unsigned LOW_CYCLES = 3
) (
    input  logic clk,
    input  logic por_i,
    input  logic por_opt_i,
    input  logic cyc_en_i,
    input  logic sync_i,
    output logic qual_o
);
    localparam int unsigned CW = $clog2(LOW_CYCLES + 1);
    localparam logic [CW-1:0] LIMIT = CW'(LOW_CYCLES);

    typedef struct packed {
        logic [CW-1:0] cnt;
        logic          qual;
    } cnt_st_t;

    cnt_st_t st_d, st_q;

    always_comb begin
        st_d = st_q;
        if (por_i) begin
            st_d.cnt = por_opt_i ? LIMIT : '0;
        end else if (sync_i) begin
            st_d.cnt = '0;
        end else if (cyc_en_i && (st_q.cnt < LIMIT)) begin
            st_d.cnt = st_q.cnt + 1'b1;
        end
        st_d.qual = (st_d.cnt == LIMIT);
    end

    always_ff @(posedge clk) begin
        st_q <= st_d;
    end

    assign qual_o = st_q.qual;

    // R2: a high synchronized request empties the count on the next clock
    a_r2_high_clears: assert property (@(posedge clk) disable iff (por_i)
        sync_i |=> (st_q.cnt == '0));

    // R3: qualification only appears right after a counted strobe
    a_r3_needs_strobe: assert property (@(posedge clk) disable iff (por_i)
        (!$past(por_i) && $rose(qual_o)) |-> $past(cyc_en_i));

    // R3: the reset persists while the request stays low
    a_r3_persists: assert property (@(posedge clk) disable iff (por_i)
        (qual_o && !sync_i) |=> qual_o);
endmodule

// File: rtl/rq_initseq.sv
module rq_initseq #(
    parameter int unsigned NUM_WREGS = 8
) (
    input  logic                 clk,
    input  logic                 por_i,
    input  logic                 qual_i,
    output logic                 core_rst_o,
    output logic                 pc_clr_o,
    output logic [NUM_WREGS-1:0] reg_clr_o,
    output logic                 sk_set_o,
    output logic                 ram_hold_o
);
    typedef struct packed {
        logic prev;
    } seq_st_t;

    seq_st_t st_d, st_q;
    logic    rel;

    always_comb begin
        st_d      = st_q;
        st_d.prev = qual_i;
    end

    always_ff @(posedge clk) begin
        st_q <= st_d;
    end

    assign rel        = st_q.prev && !qual_i;
    assign core_rst_o = qual_i;
    assign pc_clr_o   = rel;
    assign sk_set_o   = rel;
    assign ram_hold_o = qual_i | rel;

    for (genvar g = 0; g < NUM_WREGS; g++) begin : g_regclr
        assign reg_clr_o[g] = rel;
    end

    // R4: the release strobe lasts a single clock
    a_r4_single_pulse: assert property (@(posedge clk) disable iff (por_i)
        pc_clr_o |=> !pc_clr_o);

    // R6: the memory hold only drops after the release clock
    a_r6_hold_release: assert property (@(posedge clk) disable iff (por_i)
        $fell(ram_hold_o) |-> $past(sk_set_o));
endmodule

// File: rtl/cyc_reset_qualifier.sv
module cyc_reset_qualifier #(
    parameter int unsigned LOW_CYCLES  = rq_pkg::RQ_LOW_CYCLES,
    parameter int unsigned SYNC_STAGES = rq_pkg::RQ_SYNC_STAGES,
    parameter int unsigned NUM_WREGS   = rq_pkg::RQ_NUM_WREGS
) (
    input  logic                 clk,
    input  logic                 cyc_en,
    input  logic                 ext_rst_n,
    input  logic                 por_flag,
    input  logic                 por_opt_en,
    output logic                 core_rst,
    output logic                 pc_clr,
    output logic [NUM_WREGS-1:0] reg_clr,
    output logic                 sk_set,
    output logic                 ram_hold
);
    logic sync_hi;
    logic qual;

    rq_sync #(.STAGES(SYNC_STAGES)) u_sync (
        .clk   (clk),
        .por_i (por_flag),
        .d_i   (ext_rst_n),
        .q_o   (sync_hi)
    );

    rq_lowcnt #(.LOW_CYCLES(LOW_CYCLES)) u_lowcnt (
        .clk       (clk),
        .por_i     (por_flag),
        .por_opt_i (por_opt_en),
        .cyc_en_i  (cyc_en),
        .sync_i    (sync_hi),
        .qual_o    (qual)
    );

    rq_initseq #(.NUM_WREGS(NUM_WREGS)) u_initseq (
        .clk        (clk),
        .por_i      (por_flag),
        .qual_i     (qual),
        .core_rst_o (core_rst),
        .pc_clr_o   (pc_clr),
        .reg_clr_o  (reg_clr),
        .sk_set_o   (sk_set),
        .ram_hold_o (ram_hold)
    );

    // R8: with the option off, a power-on request cannot start a reset
    a_r8_por_masked: assert property (@(posedge clk)
        (por_flag && !por_opt_en) |=> !core_rst);

    // R7: with the option on, a power-on request holds the core in reset
    a_r7_por_holds: assert property (@(posedge clk)
        (por_flag && por_opt_en) |=> core_rst);
endmodule

// File: tb/test_cyc_reset_qualifier.sv
module test_cyc_reset_qualifier;
    localparam int NW = 8;

    logic          clk = 1'b0;
    logic          cyc_en = 1'b0;
    logic          ext_rst_n = 1'b1;
    logic          por_flag = 1'b1;
    logic          por_opt_en = 1'b1;
    logic          core_rst, pc_clr, sk_set, ram_hold;
    logic [NW-1:0] reg_clr;

    int checks = 0;
    int errors = 0;
    int cycles = 0;
    int div = 4;
    int phase = 0;

    cyc_reset_qualifier #(.NUM_WREGS(NW)) i_cyc_reset_qualifier (
        .clk(clk), .cyc_en(cyc_en), .ext_rst_n(ext_rst_n), .por_flag(por_flag),
        .por_opt_en(por_opt_en), .core_rst(core_rst), .pc_clr(pc_clr),
        .reg_clr(reg_clr), .sk_set(sk_set), .ram_hold(ram_hold)
    );

    always #5 clk = ~clk;

    // reference model
    int  syncq[$];
    int  lowcnt = 0;
    bit  m_rst = 0, m_rel = 0, m_valid = 0;

    always @(posedge clk) begin
        if (por_flag) begin
            syncq = '{1, 1};
            lowcnt = por_opt_en ? 3 : 0;
            m_rel = 0;
            m_rst = por_opt_en;
        end else begin
            int s;
            bit nrst;
            s = syncq[0];
            void'(syncq.pop_front());
            syncq.push_back(int'(ext_rst_n));
            if (s != 0) lowcnt = 0;
            else if (cyc_en && lowcnt < 3) lowcnt++;
            nrst = (lowcnt == 3);
            m_rel = m_rst && !nrst;
            m_rst = nrst;
        end
        m_valid = 1;
    end

    task automatic check(string req, string what, int act, int exp);
        checks++;
        if (act != exp) begin
            errors++;
            $display("FAIL %s %s actual=%0d expected=%0d t=%0t", req, what, act, exp, $time);
        end
    endtask

    // per-clock comparison against the model
    always @(negedge clk) begin
        if (m_valid) begin
            check("R3", "core_rst", int'(core_rst), int'(m_rst));
            check("R4", "pc_clr", int'(pc_clr), int'(m_rel));
            check("R4", "sk_set", int'(sk_set), int'(m_rel));
            check("R5", "reg_clr", int'(reg_clr), m_rel ? (1 << NW) - 1 : 0);
            check("R6", "ram_hold", int'(ram_hold), int'(m_rst | m_rel));
        end
    end

    // instruction-cycle strobe generator
    always @(negedge clk) begin
        phase <= (phase + 1 >= div) ? 0 : phase + 1;
        cyc_en <= (phase == 0);
    end

    // bench data memory gated by ram_hold (R6)
    logic [7:0] mem [4];
    bit scrub = 0;
    always @(posedge clk) begin
        if (scrub && !ram_hold) mem[cycles % 4] <= 8'h00;
    end

    // watchdog
    always @(posedge clk) begin
        cycles++;
        if (cycles > 100000) begin
            errors++;
            $display("FAIL watchdog expired");
            $display("  CHECKS %0d ERRORS %0d", checks, errors);
            $finish;
        end
    end

    bit saw_rst;
    task automatic hold_low(int n);
        saw_rst = 0;
        @(negedge clk) ext_rst_n = 1'b0;
        repeat (n) begin
            @(negedge clk);
            if (core_rst) saw_rst = 1;
        end
        ext_rst_n = 1'b1;
        repeat (4) begin
            @(negedge clk);
            if (core_rst) saw_rst = 1;
        end
    endtask

    initial begin
        // R7: power-on with option enabled
        repeat (3) @(negedge clk);
        check("R7", "core_rst under power-on", int'(core_rst), 1);
        por_flag = 1'b0;
        @(negedge clk);
        check("R7", "release strobe after power-on", int'(pc_clr), 1);
        @(negedge clk);
        check("R4", "strobe one clock only", int'(pc_clr), 0);
        repeat (6) @(negedge clk);

        // R2: short low ignored
        hold_low(8);
        check("R2", "short low ignored", int'(saw_rst), 0);

        // R3: long low qualifies
        hold_low(20);
        check("R3", "long low resets core", int'(saw_rst), 1);
        repeat (6) @(negedge clk);

        // R2: one-clock high glitch inside a low restarts the count
        @(negedge clk) ext_rst_n = 1'b0;
        repeat (9) @(negedge clk);
        ext_rst_n = 1'b1;
        @(negedge clk) ext_rst_n = 1'b0;
        repeat (9) @(negedge clk);
        ext_rst_n = 1'b1;
        repeat (6) @(negedge clk);

        // release coinciding with a new low (same-cycle case)
        hold_low(16);
        @(negedge clk) ext_rst_n = 1'b0;
        repeat (2) @(negedge clk);
        ext_rst_n = 1'b1;
        hold_low(16);
        repeat (6) @(negedge clk);

        // strobe every clock: three clocks low are enough
        div = 1;
        hold_low(3);
        check("R1", "three strobes through synchronizer reset core", int'(saw_rst), 1);
        repeat (4) @(negedge clk);
        div = 4;
        repeat (6) @(negedge clk);

        // R8: power-on with option disabled
        por_opt_en = 1'b0;
        @(negedge clk) por_flag = 1'b1;
        repeat (3) @(negedge clk);
        check("R8", "masked power-on keeps core running", int'(core_rst), 0);
        por_flag = 1'b0;
        @(negedge clk);
        check("R8", "no strobe after masked power-on", int'(pc_clr), 0);
        hold_low(20);
        check("R8", "external path still resets", int'(saw_rst), 1);

        // R6: memory survives reset
        mem[0] = 8'h3c; mem[1] = 8'ha5; mem[2] = 8'h5a; mem[3] = 8'hc3;
        @(negedge clk) ext_rst_n = 1'b0;
        repeat (16) @(negedge clk);
        scrub = 1;
        repeat (6) @(negedge clk);
        ext_rst_n = 1'b1;
        repeat (3) @(negedge clk);
        while (ram_hold) @(negedge clk);
        scrub = 0;
        check("R6", "mem0 kept", int'(mem[0]), 'h3c);
        check("R6", "mem1 kept", int'(mem[1]), 'ha5);
        check("R6", "mem2 kept", int'(mem[2]), 'h5a);
        check("R6", "mem3 kept", int'(mem[3]), 'hc3);

        repeat (4) @(negedge clk);
        $display("  CHECKS %0d ERRORS %0d", checks, errors);
        $finish;
    end
endmodule